// File: doc/BRIEF.md
# Lever-Press Sequence Detector

This block watches a stream of lever presses and raises a reward flag once the presses green, green, red have arrived in that order. Each press is a single-cycle event made of a valid strobe and a one-bit colour. The detector is a four-state Moore machine, so the reward flag depends only on the stored state and never on the press currently being offered.

The transition table is deliberately irregular. Extra greens after the second green keep the machine waiting for red. Leaving the reward state depends on the colour: red starts over, green counts as a fresh first green. The current state is brought out on a two-bit port for observation. Reset is synchronous and active low. Debouncing, edge detection on raw lever wiring and press timeouts are left to surrounding logic.

Top module: `lever_seq_detect`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the state becomes 00 and `reward` is 0 from that edge on, whatever the press inputs are.
- R2: At a rising edge where `press_vld` is 0, the state does not change, whatever `press_grn` is.
- R3: From state 00 (start), a valid press with `press_grn`=0 (red) keeps state 00 and a valid press with `press_grn`=1 (green) moves to state 01.
- R4: From state 01 (one green seen), a valid red press moves to state 00 and a valid green press moves to state 10.
- R5: From state 10 (two greens seen), a valid red press moves to state 11 and a valid green press keeps state 10.
- R6: From state 11 (reward), a valid red press moves to state 00 and a valid green press moves to state 01.
- R7: `reward` is 1 exactly when the state is 11 and 0 in states 00, 01 and 10; it does not depend on `press_vld` or `press_grn` within the cycle.
- R8: `state_obs` shows the stored state as a two-bit code, bit 1 the upper state bit, one edge after the press that caused it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| press_vld | input | 1 | High for one cycle per lever press |
| press_grn | input | 1 | Colour of the press: 1 green, 0 red |
| reward | output | 1 | High while the machine sits in the reward state |
| state_obs | output | 2 | Current state code |

## Verification
A wrong stored state appears on `state_obs` at the very edge after the press that produced it, because the port is the state register itself; a corrupted state therefore shows up one cycle after the offending press. A wrong reward decode is visible in the same cycle as the state, with no added latency, and the bench also holds the press inputs at values that would matter to a Mealy output to show the flag does not follow them. A wrong transition that happens to land in a state which later converges still shows at the ports, since every step of the stimulus checks the state code, not only the reward flag.

// File: rtl/lever_seq_pkg.sv
// Package: shared state encoding of the lever-press detector.
// Assumes a two-bit state; the codes are visible at the top ports.
package lever_seq_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_START  = 2'b00,
        ST_ONE_G  = 2'b01,
        ST_TWO_G  = 2'b10,
        ST_REWARD = 2'b11
    } seq_state_e;

endpackage

// File: rtl/lever_seq_next.sv
// Module: next-state logic of the detector.
// Purely combinational. Assumes press_grn is meaningful only while
// press_vld is high; without a valid press the state is returned unchanged.
module lever_seq_next
    import lever_seq_pkg::*;
(
    input  seq_state_e cur_state,
    input  logic       press_vld,
    input  logic       press_grn,
    output seq_state_e nxt_state
);

    // Pick the successor state from the transition table.
    always_comb begin
        nxt_state = cur_state;
        if (press_vld) begin
            unique case (cur_state)
                ST_START:  nxt_state = press_grn ? ST_ONE_G : ST_START;
                ST_ONE_G:  nxt_state = press_grn ? ST_TWO_G : ST_START;
                ST_TWO_G:  nxt_state = press_grn ? ST_TWO_G : ST_REWARD;
                ST_REWARD: nxt_state = press_grn ? ST_ONE_G : ST_START;
                default:   nxt_state = ST_START;
            endcase
        end
    end

endmodule

// File: rtl/lever_seq_decode.sv
// Module: Moore output decode of the detector.
// Combinational; depends on the stored state only, never on the inputs.
module lever_seq_decode
    import lever_seq_pkg::*;
(
    input  seq_state_e               cur_state,
    output logic                     reward,
    output logic [STATE_W-1:0]       state_code
);

    // Derive the reward flag and the observable state code.
    always_comb begin
        reward     = (cur_state == ST_REWARD);
        state_code = cur_state;
    end

endmodule

// File: rtl/lever_seq_detect.sv
// Module: top of the lever-press sequence detector.
// Holds the state register and wires next-state and output logic.
// Assumes one press per valid cycle and a synchronous active-low reset.
module lever_seq_detect
    import lever_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               press_vld,
    input  logic               press_grn,
    output logic               reward,
    output logic [STATE_W-1:0] state_obs
);

    seq_state_e state_q;
    seq_state_e state_d;

    lever_seq_next u_next (
        .cur_state (state_q),
        .press_vld (press_vld),
        .press_grn (press_grn),
        .nxt_state (state_d)
    );

    // State register with synchronous reset to the start state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_START;
        else        state_q <= state_d;
    end

    lever_seq_decode u_dec (
        .cur_state  (state_q),
        .reward     (reward),
        .state_code (state_obs)
    );

endmodule

// File: rtl/lever_seq_chk.sv
// Module: protocol checker for the detector, bound to the top.
// Observes ports only.
module lever_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       press_vld,
    input logic       press_grn,
    input logic       reward,
    input logic [1:0] state_obs
);

    logic rst_seen_q;

    // Remember that reset was applied at the previous edge.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst_seen_q |-> (state_obs == 2'b00 && !reward));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !press_vld |=> $stable(state_obs));

    // R3
    from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (press_vld && state_obs == 2'b00) |=>
            state_obs == ($past(press_grn) ? 2'b01 : 2'b00));

    // R4
    from_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (press_vld && state_obs == 2'b01) |=>
            state_obs == ($past(press_grn) ? 2'b10 : 2'b00));

    // R5
    from_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (press_vld && state_obs == 2'b10) |=>
            state_obs == ($past(press_grn) ? 2'b10 : 2'b11));

    // R6
    from_reward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (press_vld && state_obs == 2'b11) |=>
            state_obs == ($past(press_grn) ? 2'b01 : 2'b00));

    // R7
    reward_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reward == (state_obs == 2'b11));

    // R7
    reward_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reward) |-> $past(press_vld && !press_grn));

endmodule

bind lever_seq_detect lever_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .press_vld (press_vld),
    .press_grn (press_grn),
    .reward    (reward),
    .state_obs (state_obs)
);

// File: tb/tb_lever_seq_detect.sv
module tb_lever_seq_detect;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 17;

    // Vector = {press_vld, press_grn, expected state after the edge}.
    localparam logic [3:0] VEC [N_VEC] = '{
        4'b10_00, // R3 red in start
        4'b11_01, // R3 green in start
        4'b10_00, // R4 red in one-green
        4'b11_01, // R3
        4'b11_10, // R4 green in one-green
        4'b11_10, // R5 green holds two-green
        4'b10_11, // R5 red to reward
        4'b10_00, // R6 red leaves reward
        4'b11_01,
        4'b11_10,
        4'b10_11,
        4'b11_01, // R6 green leaves reward
        4'b01_01, // R2 idle with green colour
        4'b11_10,
        4'b00_10, // R2 idle with red colour
        4'b10_11,
        4'b01_11  // R2 idle in reward
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       press_vld;
    logic       press_grn;
    logic       reward;
    logic [1:0] state_obs;

    int checks   = 0;
    int failures = 0;

    lever_seq_detect dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .press_vld (press_vld),
        .press_grn (press_grn),
        .reward    (reward),
        .state_obs (state_obs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [2:0] act,
                         input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: state/reward actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] st, input logic vld);
        if (!vld) return "R2";
        case (st)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    // Drive inputs, take one edge, sample one time unit later.
    task automatic step(input logic vld, input logic grn);
        press_vld = vld;
        press_grn = grn;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [1:0] prev;
        rst_n = 1'b0;
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        // R1 reset wins over a valid green press
        check("R1", {state_obs, reward}, 3'b000);
        rst_n = 1'b1;

        prev = 2'b00;
        for (int i = 0; i < N_VEC; i++) begin
            step(VEC[i][3], VEC[i][2]);
            // R7 reward follows the state; R8 state code one edge after press
            check(req_of(prev, VEC[i][3]), {state_obs, reward},
                  {VEC[i][1:0], VEC[i][1:0] == 2'b11});
            prev = VEC[i][1:0];
        end

        // R7: in reward state, changing inputs mid-cycle leaves reward high
        press_vld = 1'b1;
        press_grn = 1'b1;
        #1;
        check("R7", {state_obs, reward}, 3'b111);
        press_grn = 1'b0;
        #1;
        check("R7", {state_obs, reward}, 3'b111);

        // R1: reset from the reward state
        rst_n = 1'b0;
        step(1'b1, 1'b0);
        check("R1", {state_obs, reward}, 3'b000);
        rst_n = 1'b1;

        // R8: green, green observed as 01 then 10, reward low
        step(1'b1, 1'b1);
        check("R8", {state_obs, reward}, 3'b010);
        step(1'b1, 1'b1);
        check("R8", {state_obs, reward}, 3'b100);
        // R1: reset from two-green state with a red press that would reward
        rst_n = 1'b0;
        step(1'b1, 1'b0);
        check("R1", {state_obs, reward}, 3'b000);
        rst_n = 1'b1;
        step(1'b0, 1'b0);
        check("R2", {state_obs, reward}, 3'b000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule